// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit

This block performs clamped two's-complement arithmetic on a pair of signed operands. It offers four operations. Two are a plain sum and a plain difference. The other two first double the second operand and then form the sum or the difference. Any result that would leave the representable range is pinned to the nearest extreme instead of wrapping around. This suits signal-processing paths, where a wrapped result would flip its sign.

An operation is presented for one cycle with `inValid` high. The clamped result appears on `result` after the next rising clock edge, and `outValid` pulses high alongside it. `result` keeps that value until the next accepted operation. A sticky flag records whether any accepted operation has clamped since the flag was last cleared. In the doubling operations, a clamp in the doubling stage alone is enough to raise it. A synchronous clear input lowers the flag.

Top module: `sat_addsub_unit`

## Requirements
- R1: With `opSel` = 2'b00, `result` is `opA + opB` whenever that value fits in W signed bits; otherwise the sum is clamped.
- R2: With `opSel` = 2'b01, `result` is `opA - opB` whenever that value fits in W signed bits; otherwise the difference is clamped.
- R3: With `opSel` = 2'b10, `opB` is first doubled with clamping, and the doubled value is then added to `opA` with clamping.
- R4: With `opSel` = 2'b11, `opB` is first doubled with clamping, and the doubled value is then subtracted from `opA` with clamping.
- R5: A clamp toward positive gives 0x7FFFFFFF, and a clamp toward negative gives 0x80000000 (for W = 32).
- R6: An overflow in the doubling stage gives the clamped doubled value. The second stage then uses that value and clamps again only if its own sum or difference overflows.
- R7: `satSticky` goes high after the edge on which an accepted operation clamps in either stage. A clamp in the doubling stage alone sets it.
- R8: `satSticky` stays high until an edge with `stickyClr` high and no clamping operation. When both happen on the same edge, setting wins.
- R9: `outValid` is high exactly in the cycle after a cycle with `inValid` high. `result` changes only on such edges and otherwise holds its value.
- R10: While reset is asserted, `outValid`, `satSticky` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 2 | Operation: 00 add, 01 subtract, 10 doubling add, 11 doubling subtract |
| opA | input | W | First signed operand |
| opB | input | W | Second signed operand (the one doubled) |
| stickyClr | input | 1 | Synchronous clear of the sticky flag |
| outValid | output | 1 | Result produced on the previous edge |
| result | output | W | Registered clamped result |
| satSticky | output | 1 | Sticky clamp indicator |

## Verification
On every cycle, the assertions check the one-cycle valid timing and the holding of `result` between operations. They also check that the sticky flag is kept and cleared correctly. They check that a plain sum of operands with the same sign, or a plain difference of operands with opposite signs, never changes sign. They also check that a doubling operation with a zero `opB` passes `opA` through. The exact clamped values, the two-stage order of the doubling operations, and the priority of setting over clearing can only be shown by the bench's directed and pseudo-random scenarios. There, each result is compared against wide-integer arithmetic.

// File: rtl/sat_addsub_pkg.sv
package sat_addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadResult;
    logic useDouble;
    logic doSub;
  } dpStrobe_t;

endpackage

// File: rtl/sat_addsub_clamp.sv
// Replaces a raw value with the extreme of its direction on overflow.
module sat_addsub_clamp #(
  parameter int W = 32
) (
  input  logic [W-1:0] rawVal,
  input  logic         overflow,
  input  logic         towardNeg,
  output logic [W-1:0] clampVal
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  always_comb begin
    if (!overflow)      clampVal = rawVal;
    else if (towardNeg) clampVal = MINV;
    else                clampVal = MAXV;
  end
endmodule

// File: rtl/sat_addsub_dp.sv
module sat_addsub_dp
  import sat_addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         satHit,
  output logic [W-1:0] result
);
  localparam int MSB = W - 1;

  logic         dblOvf;
  logic [W-1:0] dblRaw;
  logic [W-1:0] dblVal;
  logic [W-1:0] secondOp;
  logic [W-1:0] rawSum;
  logic         sameSign;
  logic         sumOvf;
  logic [W-1:0] finalVal;
  logic [W-1:0] resultQ;

  // stage 1: doubling of opB, overflow when the top two bits differ
  always_comb begin
    dblRaw = {opB[MSB-1:0], 1'b0};
    dblOvf = strobe.useDouble && (opB[MSB] ^ opB[MSB-1]);
  end

  sat_addsub_clamp #(.W(W)) dblClamp (
    .rawVal   (dblRaw),
    .overflow (dblOvf),
    .towardNeg(opB[MSB]),
    .clampVal (dblVal)
  );

  // stage 2: sum or difference
  always_comb begin
    secondOp = strobe.useDouble ? dblVal : opB;
    rawSum   = strobe.doSub ? (opA - secondOp) : (opA + secondOp);
    sameSign = (opA[MSB] == secondOp[MSB]);
    sumOvf   = (strobe.doSub ? !sameSign : sameSign) && (rawSum[MSB] != opA[MSB]);
  end

  sat_addsub_clamp #(.W(W)) sumClamp (
    .rawVal   (rawSum),
    .overflow (sumOvf),
    .towardNeg(opA[MSB]),
    .clampVal (finalVal)
  );

  assign satHit = dblOvf | sumOvf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  resultQ <= '0;
    else if (strobe.loadResult) resultQ <= finalVal;
  end

  assign result = resultQ;
endmodule

// File: rtl/sat_addsub_ctrl.sv
module sat_addsub_ctrl
  import sat_addsub_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic       stickyClr,
  input  logic       satHit,
  output dpStrobe_t  strobe,
  output logic       outValid,
  output logic       satSticky
);
  opKind_e   opKind;
  logic      validQ;
  logic      stickyQ;

  always_comb begin
    opKind = opKind_e'(opSel);
    strobe = '0;
    strobe.loadResult = inValid;
    unique case (opKind)
      OP_ADD:  begin strobe.useDouble = 1'b0; strobe.doSub = 1'b0; end
      OP_SUB:  begin strobe.useDouble = 1'b0; strobe.doSub = 1'b1; end
      OP_DADD: begin strobe.useDouble = 1'b1; strobe.doSub = 1'b0; end
      OP_DSUB: begin strobe.useDouble = 1'b1; strobe.doSub = 1'b1; end
      default: begin strobe.useDouble = 1'b0; strobe.doSub = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      stickyQ <= 1'b0;
    end else begin
      validQ <= inValid;
      if (inValid && satHit) stickyQ <= 1'b1;   // set beats clear
      else if (stickyClr)    stickyQ <= 1'b0;
    end
  end

  assign outValid  = validQ;
  assign satSticky = stickyQ;
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
  import sat_addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         stickyClr,
  output logic         outValid,
  output logic [W-1:0] result,
  output logic         satSticky
);
  dpStrobe_t strobe;
  logic      satHit;

  sat_addsub_ctrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .stickyClr(stickyClr),
    .satHit   (satHit),
    .strobe   (strobe),
    .outValid (outValid),
    .satSticky(satSticky)
  );

  sat_addsub_dp #(.W(W)) dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .satHit(satHit),
    .result(result)
  );
endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [1:0]   opSel,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         stickyClr,
  input logic         outValid,
  input logic [W-1:0] result,
  input logic         satSticky
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid); // R9
  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !outValid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> $stable(result)); // R9
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rstN) (satSticky && !stickyClr) |=> satSticky); // R8
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN) (stickyClr && !inValid) |=> !satSticky); // R8
  AST_ADD_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b00 && opA[W-1] == opB[W-1]) |=> result[W-1] == $past(opA[W-1])); // R1
  AST_SUB_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b01 && opA[W-1] != opB[W-1]) |=> result[W-1] == $past(opA[W-1])); // R2
  AST_DADD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b10 && opB == '0) |=> result == $past(opA)); // R3
  AST_DSUB_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b11 && opB == '0) |=> result == $past(opA)); // R4
  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!outValid && !satSticky); // R10
    end
  end
endmodule

bind sat_addsub_unit sat_addsub_chk #(.W(W)) chk (.*);

// File: tb/sat_addsub_unit_test.sv
module sat_addsub_unit_test;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    bit           sat;
    string        req;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   opSel = 2'b00;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         stickyClr = 1'b0;
  logic         outValid;
  logic [W-1:0] result;
  logic         satSticky;

  int checks = 0;
  int errors = 0;
  bit monitorOn = 1'b0;
  bit doneFlag = 1'b0;
  expItem_t expQ[$];
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;   // 50 MHz

  sat_addsub_unit #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .stickyClr(stickyClr),
    .outValid(outValid), .result(result), .satSticky(satSticky)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // wide-integer reference for R1..R6
  function automatic void model(input logic [1:0] op, input logic [W-1:0] a,
                                input logic [W-1:0] b, output logic [W-1:0] res,
                                output bit sat);
    longint maxV = 64'sd2147483647;
    longint minV = -64'sd2147483648;
    longint av = longint'($signed(a));
    longint bv = longint'($signed(b));
    longint d, r;
    sat = 1'b0;
    d = bv;
    if (op[1]) begin
      d = 2 * bv;
      if (d > maxV) begin d = maxV; sat = 1'b1; end
      if (d < minV) begin d = minV; sat = 1'b1; end
    end
    r = op[0] ? av - d : av + d;
    if (r > maxV) begin r = maxV; sat = 1'b1; end
    if (r < minV) begin r = minV; sat = 1'b1; end
    res = r[W-1:0];
  endfunction

  task automatic send(input logic [1:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input bit clr, input string req);
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b; stickyClr = clr;
    model(op, a, b, it.res, it.sat);
    it.req = req;
    expQ.push_back(it);
  endtask

  task automatic idle(input bit clr);
    @(negedge clk);
    inValid = 1'b0; stickyClr = clr;
    opA = rng; opB = ~rng; opSel = rng[1:0];
  endtask

  // monitor: scoreboard and sticky model
  initial begin : monitor
    bit expSticky = 1'b0;
    logic [W-1:0] lastRes = '0;
    forever begin
      bit vNow, cNow;
      @(posedge clk);
      vNow = inValid; cNow = stickyClr;
      #2;
      if (monitorOn) begin
        check(outValid == vNow, "R9", "outValid", {31'd0, outValid}, {31'd0, vNow});
        if (vNow) begin
          expItem_t it;
          if (expQ.size() == 0) begin
            check(1'b0, "R9", "unexpected result", result, '0);
          end else begin
            it = expQ.pop_front();
            check(result == it.res, it.req, "result", result, it.res);
            if (it.sat) expSticky = 1'b1;
            else if (cNow) expSticky = 1'b0;
            lastRes = it.res;
          end
        end else begin
          check(result == lastRes, "R9", "held result", result, lastRes);
          if (cNow) expSticky = 1'b0;
        end
        check(satSticky == expSticky, "R7/R8 sticky", "satSticky",
              {31'd0, satSticky}, {31'd0, expSticky});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && satSticky == 1'b0 && result == '0, "R10",
          "reset state", {outValid, satSticky, result[29:0]}, '0);
    @(negedge clk);
    rstN = 1'b1;
    monitorOn = 1'b1;

    // R1 and R5
    send(2'b00, 32'd5, 32'd7, 0, "R1");
    send(2'b00, 32'h7FFF_FFFF, 32'd1, 0, "R1 R5 positive clamp");
    send(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R1 R5 negative clamp");
    idle(1);   // R8 clear
    idle(0);
    // R2
    send(2'b01, 32'd10, 32'd3, 0, "R2");
    send(2'b01, 32'h8000_0000, 32'd1, 0, "R2 R5 negative clamp");
    idle(1);
    send(2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, "R2 R5 positive clamp");
    idle(1);
    // R3 and R6
    send(2'b10, 32'd3, 32'd4, 0, "R3");
    send(2'b10, 32'hFFFF_FFF0, 32'h4000_0000, 0, "R3 R6 R7 doubling clamp only");
    idle(1);
    send(2'b10, 32'd1, 32'h3000_0000, 0, "R3 no clamp");
    send(2'b10, 32'h7FFF_FFF0, 32'h0000_0010, 0, "R3 sum clamp");
    idle(1);
    // R4 and R6
    send(2'b11, 32'd100, 32'd30, 0, "R4");
    send(2'b11, 32'd0, 32'hC000_0000, 0, "R4 exact double then clamp");
    idle(1);
    send(2'b11, 32'hFFFF_FFFF, 32'h8000_0000, 0, "R4 R6 R7 doubling clamp only");
    // R8 set wins over clear
    send(2'b00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, "R8 set beats clear");
    idle(0);
    idle(0);
    send(2'b00, 32'd1, 32'd1, 1, "R8 clear with clean op");
    idle(0);

    // pseudo-random mix
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] a, b;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      a = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      b = (rng[3:0] == 4'd0) ? (rng >> 8) : rng;
      if (rng[7:5] == 3'd0) idle(rng[9]);
      else send(rng[11:10], a, b, rng[12] & rng[13], "R1 R2 R3 R4 mix");
    end
    idle(0);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9", "pending results", expQ.size(), 0);
    doneFlag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule